// File: doc/BRIEF.md
# Transmit arbitration loss monitor

This block watches a frame while the local node transmits on a shared variable-pulse-width bus. For every symbol it compares what the transmitter is driving with what the line decoder reads back. When the two disagree on a data bit, the node has lost arbitration to another node. The block then forces the output driver to its passive level, and the driver stays passive until an end-of-data symbol appears on the input.

The reaction to a loss depends on the kind of frame being sent. For messages and for in-frame responses of type 1 and type 3, a loss raises a one-cycle lost-arbitration pulse and a one-cycle pulse that cancels the opcode queued for the current frame. A type 2 response does not raise the lost-arbitration pulse. Instead it asks for a retry of its address byte. It does so only while the frame has not reached its maximum length and the length limit is enforced. When no retry is possible, the type 2 loss cancels the queued opcode.

The block counts the data symbols received since the last start-of-frame symbol, and uses this count to decide whether a retry is still allowed. All outputs are registered. Each output reacts in the cycle after the strobed symbol.

Top module: `arb_loss_monitor`

## Requirements
- R1: After reset, `tla_set`, `cancel_cur`, `retry_addr` and `drv_passive` are all 0.
- R2: With `frm_type` set to 0, 1, 2, 5 or 6, a strobed symbol pair with both symbols data (bit 1 = 0) and differing bit 0 is a loss. On the next cycle it gives `tla_set`=1 and `cancel_cur`=1, each for one cycle, and `drv_passive` becomes 1.
- R3: A symbol with bit 1 = 1 (2 = start of frame, 3 = end of data or break) on either side is never compared, and it causes no loss.
- R4: A loss requires `sym_vld`=1. Equal data symbols never cause a loss.
- R5: With `frm_type` 3 or 4 (type 2 response), a loss gives no `tla_set` and sets `drv_passive`. It pulses `retry_addr` for one cycle when `no_len_mode`=0 and the received data-symbol count is below MAX_FRAME_BITS.
- R6: A type 2 loss with the count at MAX_FRAME_BITS, or with `no_len_mode`=1, gives no `retry_addr` and pulses `cancel_cur`.
- R7: While `drv_passive`=1, further mismatches produce no pulses, and `drv_passive` holds until `eod_det`.
- R8: `eod_det`=1 while `drv_passive`=1 clears `drv_passive` on the next cycle.
- R9: With `frm_type`=7 (not transmitting), no comparison is made.
- R10: A strobed received start-of-frame symbol (code 2) clears the data-symbol count to 0. Each strobed received data symbol increments the count, and the count saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_vld | input | 1 | Symbol strobe |
| rx_sym | input | 2 | Decoded received symbol: 0/1 data bit, 2 start of frame, 3 end of data or break |
| tx_sym | input | 2 | Symbol being driven, same encoding |
| frm_type | input | 3 | 0 msg, 1 msg+CRC, 2 type1, 3 type2, 4 type2+CRC, 5 type3, 6 type3+CRC, 7 idle |
| no_len_mode | input | 1 | 1 = frame length limit not enforced |
| eod_det | input | 1 | End-of-data detected on the input line |
| tla_set | output | 1 | Lost-arbitration set pulse |
| cancel_cur | output | 1 | Cancel pulse for the current-frame opcode |
| retry_addr | output | 1 | Retry request for the type 2 address byte |
| drv_passive | output | 1 | Force the output driver passive |

## Verification
The assertions check, on every cycle, the relations among the outputs:
- a lost-arbitration pulse always comes with a cancel pulse and never with a retry;
- pulses are single cycles;
- the passive state holds until end of data and releases one cycle after it;
- no pulse appears without a strobe in the previous cycle.

Only the bench scenarios can show the following:
- which frame types are exempt from the lost-arbitration pulse;
- that non-data symbols and the idle type are ignored;
- the exact boundary of the frame-length retry limit after a start-of-frame symbol.

// File: rtl/arb_loss_monitor.sv
module arb_loss_monitor #(
  parameter int MAX_FRAME_BITS = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_vld,
  input  logic [1:0] rx_sym,
  input  logic [1:0] tx_sym,
  input  logic [2:0] frm_type,
  input  logic       no_len_mode,
  input  logic       eod_det,
  output logic       tla_set,
  output logic       cancel_cur,
  output logic       retry_addr,
  output logic       drv_passive
);
  localparam int CW = $clog2(MAX_FRAME_BITS + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAX_FRAME_BITS);

  typedef enum logic {ACTIVE, LOST} st_t;
  st_t st;
  logic [CW-1:0] bit_cnt;

  wire both_data = !rx_sym[1] && !tx_sym[1];
  wire sending   = frm_type != 3'd7;
  wire is_t2     = (frm_type == 3'd3) || (frm_type == 3'd4);
  wire loss      = sym_vld && sending && both_data && (rx_sym[0] != tx_sym[0]) && (st == ACTIVE);
  wire can_retry = !no_len_mode && (bit_cnt < CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ACTIVE;
      tla_set    <= 1'b0;
      cancel_cur <= 1'b0;
      retry_addr <= 1'b0;
    end else begin
      tla_set    <= loss && !is_t2;
      retry_addr <= loss && is_t2 && can_retry;
      cancel_cur <= loss && !(is_t2 && can_retry);
      if (st == ACTIVE && loss) st <= LOST;
      else if (st == LOST && eod_det) st <= ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_cnt <= '0;
    else if (sym_vld && rx_sym == 2'd2) bit_cnt <= '0;
    else if (sym_vld && !rx_sym[1] && bit_cnt != CMAX) bit_cnt <= bit_cnt + 1'b1;
  end

  assign drv_passive = (st == LOST);
endmodule

module arb_loss_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic sym_vld,
  input logic eod_det,
  input logic tla_set,
  input logic cancel_cur,
  input logic retry_addr,
  input logic drv_passive
);
  AST_TLA_WITH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n) tla_set |-> cancel_cur && !retry_addr); // R2
  AST_TLA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tla_set |=> !tla_set && drv_passive); // R2
  AST_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) retry_addr |-> !tla_set && !cancel_cur && drv_passive); // R5
  AST_PASSIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) drv_passive && !eod_det |=> drv_passive); // R7
  AST_EOD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) drv_passive && eod_det |=> !drv_passive); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_passive) |-> $past(sym_vld)); // R4
  AST_NO_PULSE_LOST: assert property (@(posedge clk) disable iff (!rst_n) drv_passive && !eod_det |=> !cancel_cur && !retry_addr); // R7
endmodule

bind arb_loss_monitor arb_loss_monitor_chk chk_i (.*);

// File: tb/arb_loss_monitor_tb_top.sv
module arb_loss_monitor_tb_top;
  localparam int MAXB = 96;
  logic clk = 0, rst_n = 0;
  logic sym_vld = 0, no_len_mode = 0, eod_det = 0;
  logic [1:0] rx_sym = 0, tx_sym = 0;
  logic [2:0] frm_type = 3'd7;
  logic tla_set, cancel_cur, retry_addr, drv_passive;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  arb_loss_monitor #(.MAX_FRAME_BITS(MAXB)) dut_i (.*);

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act = {tla_set, cancel_cur, retry_addr, drv_passive};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b (tla,cancel,retry,passive)", req, act, exp);
    end
  endtask

  task automatic sym(logic [1:0] r, logic [1:0] t, logic [2:0] ft);
    @(negedge clk);
    rx_sym = r; tx_sym = t; frm_type = ft; sym_vld = 1;
    @(negedge clk);
    sym_vld = 0;
  endtask

  task automatic eod();
    @(negedge clk); eod_det = 1;
    @(negedge clk); eod_det = 0;
  endtask

  task automatic t_reset();
    check("R1", 4'b0000);
  endtask

  task automatic t_match();
    sym(2'd1, 2'd1, 3'd0); check("R4 match", 4'b0000);
    @(negedge clk); rx_sym = 2'd0; tx_sym = 2'd1; frm_type = 3'd0; sym_vld = 0;
    @(negedge clk); check("R4 no strobe", 4'b0000);
  endtask

  task automatic t_nondata();
    sym(2'd2, 2'd0, 3'd0); check("R3 sof", 4'b0000);
    sym(2'd3, 2'd1, 3'd1); check("R3 eod", 4'b0000);
    sym(2'd0, 2'd3, 3'd5); check("R3 tx nondata", 4'b0000);
  endtask

  task automatic t_idle();
    sym(2'd0, 2'd1, 3'd7); check("R9", 4'b0000);
  endtask

  task automatic t_msg_loss();
    sym(2'd0, 2'd1, 3'd0); check("R2 pulse", 4'b1101);
    @(negedge clk); check("R2 single", 4'b0001);
    sym(2'd1, 2'd0, 3'd0); check("R7 no repeat", 4'b0001);
    eod(); check("R8 release", 4'b0000);
  endtask

  task automatic t_ifr3crc_loss();
    sym(2'd1, 2'd0, 3'd6); check("R2 type3crc", 4'b1101);
    eod();
  endtask

  task automatic t_t2_retry();
    sym(2'd2, 2'd2, 3'd3);
    sym(2'd1, 2'd0, 3'd3); check("R5 retry", 4'b0011);
    @(negedge clk); check("R5 single", 4'b0001);
    eod();
  endtask

  task automatic t_t2_limit();
    sym(2'd2, 2'd2, 3'd4);
    for (int i = 0; i < MAXB - 1; i++) sym(2'd0, 2'd0, 3'd4);
    sym(2'd1, 2'd0, 3'd4); check("R5 below limit", 4'b0011);
    eod();
    sym(2'd2, 2'd2, 3'd4); check("R10 sof", 4'b0000);
    for (int i = 0; i < MAXB; i++) sym(2'd1, 2'd1, 3'd4);
    sym(2'd0, 2'd1, 3'd4); check("R6 at limit", 4'b0101);
    eod();
    sym(2'd2, 2'd2, 3'd3);
    sym(2'd1, 2'd0, 3'd3); check("R10 count cleared", 4'b0011);
    eod();
  endtask

  task automatic t_t2_nfl();
    no_len_mode = 1;
    sym(2'd2, 2'd2, 3'd3);
    sym(2'd0, 2'd1, 3'd3); check("R6 nfl", 4'b0101);
    eod(); check("R8 after nfl", 4'b0000);
    no_len_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_match();
    t_nondata();
    t_idle();
    t_msg_loss();
    t_ifr3crc_loss();
    t_t2_retry();
    t_t2_limit();
    t_t2_nfl();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule